// File: doc/BRIEF.md
# Receive Frame Filter and Paged Ring Writer

This block sits between a receive byte stream and the local packet memory of a simple network controller. Each incoming frame is screened against the station address, the broadcast and group-address rules and the receive configuration, and accepted frames are stored in a circular buffer made of 256-byte pages. Every stored frame is preceded by a 4-byte header that carries a status byte, the page number where the following frame will begin, and the stored length.

Bytes are written to memory as they arrive, starting four bytes past the frame's base address. The header is written last, once the length and the filter verdict are known. Until the header is written, the current-page output does not move, so a rejected frame leaves only unused bytes in free ring space. After an accepted frame, the block publishes the new current page and pulses the receive interrupt for one cycle. Software frees ring space by moving the boundary page. The block reads the current page from its input, so the surrounding register file normally loads `rx_cur_pg` back into `cur_pg`.

Top module: `rx_page_ring_writer`

## Requirements
- R1: When `stopped` is high as the first byte of a frame is taken, the frame is discarded: no memory write, no interrupt and no change of `rx_cur_pg`.
- R2: Free space in bytes is B−C when C<B, otherwise (P−S)−(C−B), where C, B, S and P are `cur_pg`, `bnd_pg`, `start_pg` and `stop_pg` times 256. A frame that starts while the free space is below 1518 is discarded with no memory write.
- R3: When `rx_cfg` bit 4 is set, every frame is accepted whatever its destination.
- R4: Otherwise, a destination of six 0xFF bytes is accepted only when `rx_cfg` bit 2 is set.
- R5: Otherwise, a destination whose first byte has bit 0 set is accepted only when `rx_cfg` bit 3 is set and `mcast_tbl[n]` is 1. The index n is bits 31:26 of a CRC register that starts at all ones and processes the 48 destination bits, bit 0 of byte 0 first. For each bit it shifts left and XORs 0x04C11DB7 when the old bit 31 differs from the data bit.
- R6: Any other destination is accepted only when all six bytes equal `station`, with byte i of the address held in bits 8i+7:8i.
- R7: A frame shorter than 60 bytes is stored with zero bytes appended up to 60, and the length field counts the padded size.
- R8: The header sits at the base address in four consecutive bytes: status, next page, length low and length high. The length is the stored size plus 4. The status is 0x01, or 0x21 when bit 0 of the first destination byte is set.
- R9: The next page is base + ((length+4+255) rounded down to a multiple of 256). When this reaches P, (P−S) is subtracted. After the header, `rx_cur_pg` takes this page, `rx_status` takes the status byte, and `rx_irq` is high for exactly one cycle.
- R10: Frame byte k goes to base+4+k, advancing one address per byte. When the next address would equal P it becomes S.
- R11: The base address is C, unless `cur_pg` is at or above MEM_END_PG (default 0xC0), in which case it is S.
- R12: A frame longer than 1514 bytes is not accepted: no header, no interrupt, no change of `rx_cur_pg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte, destination first |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte taken when high together with in_valid |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page just past the ring |
| bnd_pg | input | 8 | Oldest page not yet freed by software |
| cur_pg | input | 8 | Page where the next frame is stored |
| station | input | 48 | Station address, byte 0 in bits 7:0 |
| mcast_tbl | input | 64 | Group-address hash table |
| rx_cfg | input | 8 | Bit 2 broadcast, bit 3 group, bit 4 accept-all |
| stopped | input | 1 | Controller stopped |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| rx_cur_pg | output | 8 | Next page after the last accepted frame |
| rx_status | output | 8 | Status byte of the last accepted frame |
| rx_irq | output | 1 | One-cycle strobe per accepted frame |

## Verification
Memory writes come from a register, so the write for a byte taken at clock edge k appears at the ports after edge k. Padding bytes follow one per cycle after the last input byte. The four header writes come next, and `rx_cur_pg`, `rx_status` and `rx_irq` update on the edge of the final header write. At most about 65 cycles pass between the last input byte and that edge. The bench records every write and every interrupt on the falling edge, waits a fixed 80 cycles after each frame, and only then compares header, data, padding, page and interrupt count with values derived from the rules above. For rejected frames, the checks look for a missing header, an unchanged current page and no new interrupt.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

    localparam int HDR_LEN   = 4;
    localparam int CRC_ROOM  = 4;
    localparam logic [31:0] HASH_POLY = 32'h04C1_1DB7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_DROP,
        S_PAD,
        S_HDR
    } wr_state_e;

    typedef struct packed {
        logic accept_all;
        logic group_en;
        logic bcast_en;
    } rx_mode_t;

    function automatic rx_mode_t decode_mode(input logic [7:0] cfg);
        rx_mode_t m;
        m.accept_all = cfg[4];
        m.group_en   = cfg[3];
        m.bcast_en   = cfg[2];
        return m;
    endfunction

    // Group-address hash: serial CRC over the destination, low bit of byte 0 first.
    function automatic logic [5:0] group_hash(input logic [47:0] dst);
        logic [31:0] crc;
        logic        fb;
        crc = '1;
        for (int i = 0; i < 48; i++) begin
            fb  = crc[31] ^ dst[i];
            crc = {crc[30:0], 1'b0};
            if (fb) crc = crc ^ HASH_POLY;
        end
        return crc[31:26];
    endfunction

endpackage

// File: rtl/rpr_filter.sv
module rpr_filter
    import rpr_pkg::*;
(
    input  logic [47:0] dst,
    input  logic [47:0] station,
    input  logic [63:0] mcast_tbl,
    input  rx_mode_t    mode,
    output logic        accept,
    output logic        group
);
    logic       all_ones;
    logic       exact;
    logic [5:0] hidx;

    always_comb begin
        all_ones = &dst;
        group    = dst[0];
        exact    = (dst == station);
        hidx     = group_hash(dst);
        if (mode.accept_all)
            accept = 1'b1;
        else if (all_ones)
            accept = mode.bcast_en;
        else if (group)
            accept = mode.group_en && mcast_tbl[hidx];
        else
            accept = exact;
    end
endmodule

// File: rtl/rpr_space.sv
module rpr_space #(
    parameter int PG_W       = 8,
    parameter int MAX_FRAME  = 1514,
    parameter logic [PG_W-1:0] MEM_END_PG = 8'hC0,
    localparam int ADDR_W    = PG_W + 8
) (
    input  logic [PG_W-1:0]   start_pg,
    input  logic [PG_W-1:0]   stop_pg,
    input  logic [PG_W-1:0]   bnd_pg,
    input  logic [PG_W-1:0]   cur_pg,
    output logic              room_ok,
    output logic [ADDR_W-1:0] base_addr
);
    localparam int NEED = MAX_FRAME + rpr_pkg::CRC_ROOM;

    int c_b, b_b, s_b, p_b, avail;

    always_comb begin
        c_b = int'(cur_pg)   * 256;
        b_b = int'(bnd_pg)   * 256;
        s_b = int'(start_pg) * 256;
        p_b = int'(stop_pg)  * 256;
        if (c_b < b_b)
            avail = b_b - c_b;
        else
            avail = (p_b - s_b) - (c_b - b_b);
        room_ok = (avail >= NEED);
        if (cur_pg >= MEM_END_PG)
            base_addr = {start_pg, 8'h00};
        else
            base_addr = {cur_pg, 8'h00};
    end
endmodule

// File: rtl/rpr_writer.sv
module rpr_writer
    import rpr_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60,
    localparam int ADDR_W   = PG_W + 8,
    localparam int CNT_W    = $clog2(MAX_FRAME + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              stopped,
    input  logic [PG_W-1:0]   start_pg,
    input  logic [PG_W-1:0]   stop_pg,
    input  logic              room_ok,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              accept,
    output logic [47:0]       dst,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PG_W-1:0]   rx_cur_pg,
    output logic [7:0]        rx_status,
    output logic              rx_irq
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);

    wr_state_e         st;
    logic [ADDR_W-1:0] base_q, wa;
    logic [CNT_W-1:0]  cnt;
    logic [47:0]       dst_q;
    logic              over_q;
    logic [1:0]        hsel;

    logic [ADDR_W-1:0] ring_lo, ring_hi;
    logic [ADDR_W-1:0] total;
    logic [ADDR_W:0]   span, nxt, hi_e;
    logic [PG_W-1:0]   next_pg;
    logic [7:0]        stat_b, hdr_b;
    logic              keep;

    function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                               input logic [ADDR_W-1:0] lo,
                                               input logic [ADDR_W-1:0] hi);
        logic [ADDR_W-1:0] a1;
        a1 = a + 1'b1;
        return (a1 == hi) ? lo : a1;
    endfunction

    assign dst      = dst_q;
    assign in_ready = (st == S_IDLE) || (st == S_RECV) || (st == S_DROP);

    always_comb begin
        ring_lo = {start_pg, 8'h00};
        ring_hi = {stop_pg, 8'h00};
        hi_e    = {1'b0, ring_hi};
        total   = ADDR_W'(cnt) + ADDR_W'(HDR_LEN);
        span    = ({1'b0, total} + (ADDR_W+1)'(CRC_ROOM + 255)) & ~(ADDR_W+1)'(255);
        nxt     = {1'b0, base_q} + span;
        if (nxt >= hi_e)
            nxt = nxt - (hi_e - {1'b0, ring_lo});
        next_pg = nxt[ADDR_W-1:8];
        stat_b  = dst_q[0] ? 8'h21 : 8'h01;
        keep    = accept && !over_q;
        case (hsel)
            2'd0:    hdr_b = stat_b;
            2'd1:    hdr_b = 8'(next_pg);
            2'd2:    hdr_b = total[7:0];
            default: hdr_b = total[15:8];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            base_q    <= '0;
            wa        <= '0;
            cnt       <= '0;
            dst_q     <= '0;
            over_q    <= 1'b0;
            hsel      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rx_cur_pg <= '0;
            rx_status <= '0;
            rx_irq    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            rx_irq <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (in_valid) begin
                        if (stopped || !room_ok) begin
                            st <= in_last ? S_IDLE : S_DROP;
                        end else begin
                            base_q        <= base_addr;
                            mem_we        <= 1'b1;
                            mem_addr      <= base_addr + ADDR_W'(HDR_LEN);
                            mem_wdata     <= in_data;
                            wa            <= step(base_addr + ADDR_W'(HDR_LEN), ring_lo, ring_hi);
                            cnt           <= CNT_W'(1);
                            dst_q         <= {40'h0, in_data};
                            over_q        <= 1'b0;
                            hsel          <= '0;
                            st            <= in_last ? S_PAD : S_RECV;
                        end
                    end
                end
                S_RECV: begin
                    if (in_valid) begin
                        if (cnt < MAX_C) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= wa;
                            mem_wdata <= in_data;
                            wa        <= step(wa, ring_lo, ring_hi);
                            cnt       <= cnt + 1'b1;
                        end else begin
                            over_q <= 1'b1;
                        end
                        if (cnt < CNT_W'(6))
                            dst_q[{cnt[2:0], 3'b000} +: 8] <= in_data;
                        if (in_last)
                            st <= ((cnt + 1'b1) < MIN_C) ? S_PAD : S_HDR;
                    end
                end
                S_DROP: begin
                    if (in_valid && in_last)
                        st <= S_IDLE;
                end
                S_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= wa;
                    mem_wdata <= 8'h00;
                    wa        <= step(wa, ring_lo, ring_hi);
                    cnt       <= cnt + 1'b1;
                    if ((cnt + 1'b1) == MIN_C)
                        st <= S_HDR;
                end
                S_HDR: begin
                    if (hsel == 2'd0 && !keep) begin
                        st <= S_IDLE;
                    end else begin
                        mem_we    <= 1'b1;
                        mem_addr  <= base_q + ADDR_W'(hsel);
                        mem_wdata <= hdr_b;
                        hsel      <= hsel + 1'b1;
                        if (hsel == 2'd3) begin
                            rx_cur_pg <= next_pg;
                            rx_status <= stat_b;
                            rx_irq    <= 1'b1;
                            st        <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1: a frame started while stopped produces no write
    p_stop_no_write_r1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && in_valid && stopped) |=> !mem_we);

    // R2: a frame started without room produces no write
    p_room_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && in_valid && !room_ok) |=> !mem_we);

    // R7: every padding cycle writes a zero byte
    p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_PAD) |=> (mem_we && mem_wdata == 8'h00));

    // R8: the first header write lands at the base with the good-frame bit set
    p_hdr_first_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_HDR && hsel == 2'd0 && keep) |=> (mem_we && mem_addr == base_q && mem_wdata[0]));

    // R9: interrupt is a single-cycle strobe
    p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    // R9: the published page only moves together with the interrupt
    p_cur_with_irq_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_cur_pg) |-> rx_irq);
endmodule

// File: rtl/rx_page_ring_writer.sv
module rx_page_ring_writer
    import rpr_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60,
    parameter logic [PG_W-1:0] MEM_END_PG = 8'hC0,
    localparam int ADDR_W   = PG_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [PG_W-1:0]   start_pg,
    input  logic [PG_W-1:0]   stop_pg,
    input  logic [PG_W-1:0]   bnd_pg,
    input  logic [PG_W-1:0]   cur_pg,
    input  logic [47:0]       station,
    input  logic [63:0]       mcast_tbl,
    input  logic [7:0]        rx_cfg,
    input  logic              stopped,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PG_W-1:0]   rx_cur_pg,
    output logic [7:0]        rx_status,
    output logic              rx_irq
);
    logic              room_ok;
    logic [ADDR_W-1:0] base_addr;
    logic              accept;
    logic              group;
    logic [47:0]       dst;
    rx_mode_t          mode;

    assign mode = decode_mode(rx_cfg);

    rpr_space #(
        .PG_W(PG_W), .MAX_FRAME(MAX_FRAME), .MEM_END_PG(MEM_END_PG)
    ) u_space (
        .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
        .room_ok(room_ok), .base_addr(base_addr)
    );

    rpr_filter u_filter (
        .dst(dst), .station(station), .mcast_tbl(mcast_tbl), .mode(mode),
        .accept(accept), .group(group)
    );

    rpr_writer #(
        .PG_W(PG_W), .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME)
    ) u_writer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .stopped(stopped), .start_pg(start_pg), .stop_pg(stop_pg),
        .room_ok(room_ok), .base_addr(base_addr), .accept(accept), .dst(dst),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rx_cur_pg(rx_cur_pg), .rx_status(rx_status), .rx_irq(rx_irq)
    );

    // R8: a stored frame with a group destination reports the group status
    p_group_status_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && group) |-> (rx_status == 8'h21));
endmodule

// File: tb/rx_page_ring_writer_test.sv
`timescale 1ns/1ps
module rx_page_ring_writer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  start_pg = 8'h46, stop_pg = 8'h60, bnd_pg = 8'h46, cur_pg = 8'h4C;
    logic [47:0] station = 48'h56_34_12_00_54_52;
    logic [63:0] mcast_tbl = '0;
    logic [7:0]  rx_cfg = '0;
    logic        stopped = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, rx_cur_pg, rx_status;
    logic        rx_irq;

    int checks = 0, errors = 0, irq_cnt = 0;
    logic [7:0] mem [int];
    logic [7:0] fb [0:1599];

    always #2.5 clk = ~clk;

    rx_page_ring_writer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
        .cur_pg(cur_pg), .station(station), .mcast_tbl(mcast_tbl), .rx_cfg(rx_cfg),
        .stopped(stopped), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rx_cur_pg(rx_cur_pg), .rx_status(rx_status), .rx_irq(rx_irq)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            if (rx_irq) irq_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int hash_of(input logic [47:0] d);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 8; j++) begin
                logic x = r[31] ^ d[8*i + j];
                r = r << 1;
                if (x) r = r ^ 32'h04C1_1DB7;
            end
        return int'(r[31:26]);
    endfunction

    function automatic int ring(input int a);
        return (a >= int'(stop_pg) * 256) ? a - int'(stop_pg) * 256 + int'(start_pg) * 256 : a;
    endfunction

    function automatic int base_of();
        return (cur_pg >= 8'hC0) ? int'(start_pg) * 256 : int'(cur_pg) * 256;
    endfunction

    function automatic int rd(input int a);
        return mem.exists(a) ? int'(mem[a]) : -1;
    endfunction

    task automatic fill(input logic [47:0] d, input int len);
        for (int k = 0; k < len; k++)
            fb[k] = (k < 6) ? d[8*k +: 8] : 8'((k * 7 + 3) & 255);
    endtask

    task automatic send(input int len);
        mem.delete();
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[k];
            in_last  = (k == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    // Sends a frame and checks header, data, page and interrupt against the rules.
    task automatic frame(input string tag, input int len, input bit acc);
        int b, padded, total, nxt, irq0, cur0;
        b = base_of();
        padded = (len < 60) ? 60 : len;
        total = padded + 4;
        nxt = b + ((total + 4 + 255) & ~255);
        if (nxt >= int'(stop_pg) * 256) nxt -= (int'(stop_pg) - int'(start_pg)) * 256;
        irq0 = irq_cnt;
        cur0 = int'(rx_cur_pg);
        send(len);
        if (acc) begin
            int st = fb[0][0] ? 8'h21 : 8'h01;
            chk(rd(b) == st, {tag, " R8 status"}, rd(b), st);
            chk(rd(b + 1) == nxt / 256, {tag, " R8 next page"}, rd(b + 1), nxt / 256);
            chk(rd(b + 2) == (total & 255) && rd(b + 3) == total / 256,
                {tag, " R8 length"}, rd(b + 3) * 256 + rd(b + 2), total);
            chk(rd(ring(b + 4)) == int'(fb[0]), {tag, " R10 first byte"}, rd(ring(b + 4)), fb[0]);
            chk(rd(ring(b + 3 + padded)) == ((padded > len) ? 0 : int'(fb[len - 1])),
                {tag, " R10 last byte"}, rd(ring(b + 3 + padded)),
                (padded > len) ? 0 : int'(fb[len - 1]));
            chk(int'(rx_cur_pg) == nxt / 256, {tag, " R9 current page"}, rx_cur_pg, nxt / 256);
            chk(int'(rx_status) == st, {tag, " R9 status out"}, rx_status, st);
            chk(irq_cnt == irq0 + 1, {tag, " R9 one irq"}, irq_cnt - irq0, 1);
        end else begin
            chk(!mem.exists(b), {tag, " no header"}, rd(b), -1);
            chk(int'(rx_cur_pg) == cur0, {tag, " page kept"}, rx_cur_pg, cur0);
            chk(irq_cnt == irq0, {tag, " no irq"}, irq_cnt - irq0, 0);
        end
    endtask

    task automatic t_reset();
        chk(rx_cur_pg == 8'h00 && rx_status == 8'h00, "reset outputs", rx_cur_pg, 0);
        chk(!rx_irq && !mem_we && in_ready, "reset strobes", {rx_irq, mem_we, in_ready}, 1);
    endtask

    task automatic t_unicast();
        fill(station, 64);
        frame("R6 unicast match", 64, 1'b1);
        fill(station ^ 48'h0100_0000_0000, 64);
        frame("R6 unicast miss", 64, 1'b0);
    endtask

    task automatic t_bcast();
        fill('1, 70);
        rx_cfg = 8'h00;
        frame("R4 broadcast off", 70, 1'b0);
        rx_cfg = 8'h04;
        frame("R4 broadcast on", 70, 1'b1);
        rx_cfg = 8'h00;
    endtask

    task automatic t_mcast();
        logic [47:0] g = 48'h01_00_00_5E_00_01;
        int n = hash_of(g);
        fill(g, 80);
        rx_cfg = 8'h08;
        mcast_tbl = 64'd1 << n;
        frame("R5 group hash hit", 80, 1'b1);
        mcast_tbl = ~(64'd1 << n);
        frame("R5 group hash miss", 80, 1'b0);
        rx_cfg = 8'h00;
        mcast_tbl = 64'd1 << n;
        frame("R5 group disabled", 80, 1'b0);
        mcast_tbl = '0;
    endtask

    task automatic t_promisc();
        fill(48'hAB_CD_EF_01_23_44, 100);
        rx_cfg = 8'h10;
        frame("R3 accept all", 100, 1'b1);
        rx_cfg = 8'h00;
    endtask

    task automatic t_short();
        fill(station, 10);
        frame("R7 short frame", 10, 1'b1);
        chk(rd(base_of() + 4 + 30) == 0, "R7 pad byte zero", rd(base_of() + 34), 0);
        chk(rd(base_of() + 4 + 9) == int'(fb[9]), "R7 data before pad", rd(base_of() + 13), fb[9]);
    endtask

    task automatic t_wrap();
        cur_pg = 8'h5F;
        bnd_pg = 8'h50;
        fill(station, 300);
        frame("R10 ring wrap", 300, 1'b1);
        chk(rd(16'h5FFF) == int'(fb[251]), "R10 byte before stop", rd(16'h5FFF), fb[251]);
        chk(rd(16'h4600) == int'(fb[252]), "R10 byte at start", rd(16'h4600), fb[252]);
        chk(!mem.exists(16'h6000), "R10 nothing at stop", rd(16'h6000), -1);
    endtask

    task automatic t_room();
        cur_pg = 8'h50;
        bnd_pg = 8'h55;
        fill(station, 64);
        frame("R2 ring full", 64, 1'b0);
        chk(mem.num() == 0, "R2 no writes", mem.num(), 0);
        bnd_pg = 8'h57;
        frame("R2 just enough room", 64, 1'b1);
    endtask

    task automatic t_stopped();
        cur_pg = 8'h4C;
        bnd_pg = 8'h46;
        stopped = 1'b1;
        fill(station, 64);
        frame("R1 stopped", 64, 1'b0);
        chk(mem.num() == 0, "R1 no writes", mem.num(), 0);
        stopped = 1'b0;
    endtask

    task automatic t_memend();
        cur_pg = 8'hC0;
        bnd_pg = 8'hD0;
        fill(station, 64);
        frame("R11 page past memory end", 64, 1'b1);
        chk(rd(16'h4600) == 8'h01, "R11 header at start page", rd(16'h4600), 1);
        cur_pg = 8'h4C;
        bnd_pg = 8'h46;
    endtask

    task automatic t_long();
        fill(station, 1515);
        frame("R12 overlong frame", 1515, 1'b0);
        fill(station, 1514);
        frame("R12 longest frame", 1514, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast();
        t_promisc();
        t_short();
        t_wrap();
        t_room();
        t_stopped();
        t_memend();
        t_long();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule